// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block runs single accesses to a 2048-word, 16-bit peripheral I/O space. The space is split into four equal regions of 512 words. Each region has its own 3-bit wait-count register, so a slow converter in one region does not slow down fast registers in another.

When a read or write request is accepted, the block captures the address. It looks up the wait count of the region that the address falls in. It then holds the I/O strobe and the matching direction strobe for one cycle plus that many wait cycles. Ready pulses on the last strobe cycle. The peripheral gives no handshake: the wait cycles come only from the region register.

The wait registers are loaded through a small write port and reset to the maximum count. A request is taken only when no access is in progress.

Top module: `ioWaitGen`

## Requirements
- R1: Address bits 10:9 pick the wait register: 0 for 0x000–0x1FF, 1 for 0x200–0x3FF, 2 for 0x400–0x5FF, 3 for 0x600–0x7FF.
- R2: A request sampled on a clock edge while idle raises ioStrobe at that edge. ioStrobe stays high for exactly 1+W cycles, where W is the selected 3-bit register value (0..7).
- R3: ready is high for exactly one cycle, the final ioStrobe cycle. ioStrobe is low in the cycle after ready.
- R4: rdStrobe is high during a read access and wrStrobe during a write access, never both, and neither outside ioStrobe. If rdReq and wrReq are both high, the access is a read.
- R5: extAddr[10:0] carries the captured request address, held stable for the whole access. extAddr[13:11] are driven to 0.
- R6: After reset all four wait registers hold 7, and ioStrobe, rdStrobe, wrStrobe and ready are low.
- R7: A request that arrives while an access is in progress, including its ready cycle, is ignored and starts no access.
- R8: A wait-register write during an access does not change that access's length. It takes effect from the next accepted access.
- R9: A wait value of 0 gives a single-cycle access in which ioStrobe and ready are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqAddr | input | 11 | Address of the requested I/O word |
| rdReq | input | 1 | Read request, sampled while idle |
| wrReq | input | 1 | Write request, sampled while idle |
| cfgWrEn | input | 1 | Write enable for a wait register |
| cfgSel | input | 2 | Wait register index (region) to write |
| cfgData | input | 3 | New wait count |
| ioStrobe | output | 1 | I/O space select, high for the whole access |
| rdStrobe | output | 1 | Read strobe |
| wrStrobe | output | 1 | Write strobe |
| extAddr | output | 14 | External address bus; upper three bits zero |
| ready | output | 1 | One-cycle completion pulse on the last strobe cycle |

## Verification
The assertions assume that reset has been applied before the first access. They also assume that the request and configuration inputs change only between clock edges, so that each edge sees one settled value. The bench drives every input on the falling edge and samples on the falling edge. It raises requests while busy only as a deliberate check that they are ignored, and it writes wait registers both while idle and in the middle of an access.

// File: rtl/ioWaitPkg.sv
package ioWaitPkg;
  // Strobes from the sequencing control to the address/wait datapath
  typedef struct packed {
    logic capture;  // latch request address this cycle
    logic active;   // an access is in progress
  } ioCtlT;
endpackage

// File: rtl/ioWaitDatapath.sv
module ioWaitDatapath
  import ioWaitPkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int EXT_W      = 14,
  parameter int WAIT_W     = 3,
  parameter int REGION_N   = 4,
  localparam int REGION_W  = $clog2(REGION_N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                cfgWrEn,
  input  logic [REGION_W-1:0] cfgSel,
  input  logic [WAIT_W-1:0]   cfgData,
  input  ioCtlT               ctl,
  output logic [WAIT_W-1:0]   selWait,
  output logic [EXT_W-1:0]    extAddr
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  logic [WAIT_W-1:0] waitReg [REGION_N];
  logic [ADDR_W-1:0] addrQ;
  logic [REGION_W-1:0] region;

  for (genvar g = 0; g < REGION_N; g++) begin : gWaitReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        waitReg[g] <= WAIT_MAX;
      end else if (cfgWrEn && cfgSel == REGION_W'(g)) begin
        waitReg[g] <= cfgData;
      end
    end
  end

  assign region  = reqAddr[ADDR_W-1 -: REGION_W];
  assign selWait = waitReg[region];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (ctl.capture) begin
      addrQ <= reqAddr;
    end
  end

  assign extAddr = {{(EXT_W-ADDR_W){1'b0}}, addrQ};
endmodule

// File: rtl/ioWaitCtrl.sv
module ioWaitCtrl
  import ioWaitPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [WAIT_W-1:0] selWait,
  output ioCtlT             ctl,
  output logic              ioStrobe,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              ready
);
  logic              active;
  logic              isRead;
  logic [WAIT_W-1:0] remain;
  logic              accept;
  logic              lastCycle;

  assign accept    = !active && (rdReq || wrReq);
  assign lastCycle = active && (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      isRead <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      active <= 1'b1;
      isRead <= rdReq;  // read wins when both are raised
      remain <= selWait;
    end else if (lastCycle) begin
      active <= 1'b0;
    end else if (active) begin
      remain <= remain - 1'b1;
    end
  end

  assign ctl.capture = accept;
  assign ctl.active  = active;
  assign ioStrobe    = active;
  assign rdStrobe    = active && isRead;
  assign wrStrobe    = active && !isRead;
  assign ready       = lastCycle;
endmodule

// File: rtl/ioWaitGen.sv
module ioWaitGen
  import ioWaitPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int EXT_W     = 14,
  parameter int WAIT_W    = 3,
  parameter int REGION_N  = 4,
  localparam int REGION_W = $clog2(REGION_N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                rdReq,
  input  logic                wrReq,
  input  logic                cfgWrEn,
  input  logic [REGION_W-1:0] cfgSel,
  input  logic [WAIT_W-1:0]   cfgData,
  output logic                ioStrobe,
  output logic                rdStrobe,
  output logic                wrStrobe,
  output logic [EXT_W-1:0]    extAddr,
  output logic                ready
);
  ioCtlT             ctl;
  logic [WAIT_W-1:0] selWait;

  ioWaitCtrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .selWait(selWait),
    .ctl(ctl), .ioStrobe(ioStrobe), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .ready(ready)
  );

  ioWaitDatapath #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .WAIT_W(WAIT_W), .REGION_N(REGION_N)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .ctl(ctl), .selWait(selWait),
    .extAddr(extAddr)
  );
endmodule

// File: rtl/ioWaitGenChecker.sv
module ioWaitGenChecker #(
  parameter int EXT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioStrobe,
  input logic             rdStrobe,
  input logic             wrStrobe,
  input logic [EXT_W-1:0] extAddr,
  input logic             ready
);
  AST_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ioStrobe);  // R3
  AST_GAP_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ioStrobe);  // R3
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    ioStrobe |-> ($countones({rdStrobe, wrStrobe}) == 1));  // R4
  AST_NO_DIR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ioStrobe |-> !(rdStrobe || wrStrobe));  // R4
  AST_HOLD_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ioStrobe && !ready) |=> (ioStrobe && $stable(rdStrobe)));  // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ioStrobe && !ready) |=> $stable(extAddr));  // R5
endmodule

bind ioWaitGen ioWaitGenChecker #(.EXT_W(EXT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .extAddr(extAddr), .ready(ready)
);

// File: tb/ioWaitGen_tb.sv
module ioWaitGen_tb;
  typedef struct {
    bit isRd;
    int addr;
    int w;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] reqAddr = '0;
  logic        rdReq = 1'b0, wrReq = 1'b0, cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [2:0]  cfgData = '0;
  logic        ioStrobe, rdStrobe, wrStrobe, ready;
  logic [13:0] extAddr;

  int  compared = 0, mismatched = 0, finished = 0;
  bit  reported = 0;
  int  model [4] = '{7, 7, 7, 7};
  expT expQ[$];

  always #2.5 clk = ~clk;

  ioWaitGen u_dut (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .rdReq(rdReq), .wrReq(wrReq),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData), .ioStrobe(ioStrobe),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .extAddr(extAddr), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected accesses as strobes appear
  bit  inAcc = 0;
  int  cyc = 0;
  expT cur;
  always @(negedge clk) begin
    if (rstN && ioStrobe) begin
      if (!inAcc) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected access", 1, 0);
          cur = '{isRd: 1, addr: extAddr, w: 0};
        end else begin
          cur = expQ.pop_front();
        end
        inAcc = 1;
        cyc = 0;
        check(rdStrobe == cur.isRd && wrStrobe == !cur.isRd, "R4 direction",
              {rdStrobe, wrStrobe}, cur.isRd ? 2 : 1);
      end
      cyc++;
      if (cyc == 1)
        check(extAddr == 14'(cur.addr), "R5 extAddr", extAddr, cur.addr);
      if (ready) begin
        check(cyc == cur.w + 1, "R1/R2/R8/R9 access length", cyc, cur.w + 1);
        inAcc = 0;
        finished++;
      end else if (cyc > cur.w + 1) begin
        check(0, "R3 ready missing", cyc, cur.w + 1);
        inAcc = 0;
        finished++;
      end
    end else if (rstN && inAcc) begin
      check(0, "R2 strobe dropped early", cyc, cur.w + 1);
      inAcc = 0;
      finished++;
    end else if (rstN && ready) begin
      check(0, "R3 ready without strobe", 1, 0);
    end
  end

  task automatic waitDone(input int target);
    while (finished < target) @(negedge clk);
    @(negedge clk);
    check(!ioStrobe && !ready, "R3 idle after access", ioStrobe, 0);
  endtask

  task automatic cfgWrite(input int sel, input int val);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 2'(sel); cfgData = 3'(val);
    @(negedge clk);
    cfgWrEn = 0;
    model[sel] = val;
  endtask

  // mode 0: plain; 1: foreign request mid-access (R7); 2: cfg write mid-access (R8)
  task automatic access(input bit rd, input bit wr, input int addr, input int mode);
    int target;
    target = finished + 1;
    @(negedge clk);
    reqAddr = 11'(addr); rdReq = rd; wrReq = wr;
    expQ.push_back('{isRd: rd, addr: addr, w: model[addr >> 9]});
    @(negedge clk);
    rdReq = 0; wrReq = 0;
    if (mode == 1) begin
      reqAddr = 11'h7AB; wrReq = 1;
      @(negedge clk);
      wrReq = 0;
    end else if (mode == 2) begin
      cfgWrEn = 1; cfgSel = 2'(addr >> 9); cfgData = 3'd2;
      @(negedge clk);
      cfgWrEn = 0;
      model[addr >> 9] = 2;
    end
    waitDone(target);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!reported) begin
      reported = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", finished, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ioStrobe && !rdStrobe && !wrStrobe && !ready, "R6 reset outputs", ioStrobe, 0);
    rstN = 1;
    @(negedge clk);
    check(!ioStrobe && !ready, "R6 idle after reset", ioStrobe, 0);
    access(1, 0, 'h123, 0);            // R6: default 7 waits -> 8 cycles
    access(0, 1, 'h6F0, 0);            // R6: region 3 default too
    cfgWrite(0, 0); cfgWrite(1, 3); cfgWrite(2, 5); cfgWrite(3, 1);
    access(1, 0, 'h000, 0);            // R9 single cycle
    access(0, 1, 'h1FF, 0);            // R1 region 0 top
    access(1, 0, 'h200, 0);            // R1 region 1 bottom
    access(0, 1, 'h3FF, 0);
    access(1, 0, 'h400, 0);            // R1 region 2
    access(0, 1, 'h5FF, 0);
    access(1, 0, 'h600, 0);            // R1 region 3
    access(0, 1, 'h7FF, 0);
    access(1, 1, 'h2AA, 0);            // R4 read wins
    access(0, 1, 'h450, 1);            // R7 intruding request
    access(1, 0, 'h4AA, 2);            // R8 old value 5 used
    access(0, 1, 'h4AB, 0);            // R8 new value 2 used
    access(1, 0, 'h055, 0);            // R9 again after others
    repeat (4) @(negedge clk);
    check(expQ.size() == 0 && !ioStrobe, "R7 no stray access", expQ.size(), 0);
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule